// File: doc/BRIEF.md
# Host Data Port with Wait-State Handshake

This block is the single-word data window through which a host on an ISA-style bus streams a remote transfer into or out of the local buffer memory. Software first programs a start address, a byte count and a direction, then pulses a start input. From that point the host simply reads or writes the one data port over and over. A holding register sits between the host and the memory. On a read transfer it is filled ahead of the host. On a write transfer it takes the host word and then drains it to memory.

When the host touches the port before the holding register can serve it, the ready output is dropped in the same cycle as the strobe, and the host cycle is stretched until the register can serve it. Every address the transfer passes through is decoded against a local map that depends on the mode latched at start. In 16-bit mode a 32-byte register area sits at the bottom and memory lies above it. In 8-bit mode the register area is aliased across the lower 16 KB, the 8 KB buffer follows it, and a reserved window sits on top. The register area holds the station address and a signature byte that tells software which mode is in use. Accesses to the register area and to the reserved window never reach the memory port.

Top module: `host_data_port`

## Requirements
- R1: After reset, and whenever no transfer is active, host_rdy is high under either strobe, host_rdata is 0000h, mem_req is low and xfer_done is low until the first transfer completes.
- R2: On a read transfer the next word is fetched into the holding register without waiting for the host. A host read that finds the register empty sees host_rdy low in the same cycle and stays held until the word arrives. The read that is accepted returns that word.
- R3: After a fetched word lands in the holding register, no further memory read is issued until the host has taken that word.
- R4: On a write transfer, a host write that finds the holding register empty is accepted at once. A host write that arrives while the previous word is still uncommitted sees host_rdy low until that word has been written to memory at the current address.
- R5: No memory write is issued until the host has supplied a new word for it.
- R6: After each word, the address advances by 2 and the count drops by 2 in 16-bit mode, or by 1 each in 8-bit mode. The count saturates at zero. xfer_done rises once the count reaches zero and stays high until the next start. A start with a zero count raises xfer_done on the next cycle and makes no memory access.
- R7: In 16-bit mode, addresses 0000h–001Fh read the register area at offset addr[4:0]. Offsets 00h–05h hold station bytes 0–5, and station byte k is station_addr[8k+7:8k]. Offsets 1Eh and 1Fh both hold 57h, and every other offset holds 00h. The byte appears in the low half and the upper byte is 00h. No memory request is made.
- R8: In 8-bit mode, every address below 4000h reads the register area decoded from addr[4:0] only. An odd offset returns the same byte as the even offset below it. Even offset 2j holds station byte j for j below 6, offsets 1Eh/1Fh hold 42h, and the rest hold 00h. No memory request is made.
- R9: In 8-bit mode, only 4000h–5FFFh reaches memory. There, reads return the low memory byte with the upper byte 00h, and writes send the low host byte with the upper byte 00h. Addresses from 6000h upward read 0000h and drop writes, with no memory access.
- R10: A host write whose address falls in the register area is dropped without a memory access, and the transfer still advances and completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode16 | input | 1 | 1 selects the 16-bit map, 0 the 8-bit map; latched at start |
| xfer_start | input | 1 | One-cycle pulse that loads a new transfer |
| xfer_write | input | 1 | Direction latched at start: 1 host-to-memory, 0 memory-to-host |
| xfer_addr | input | 16 | Start address of the transfer |
| xfer_count | input | 16 | Byte count of the transfer |
| xfer_done | output | 1 | Count has reached zero |
| station_addr | input | 48 | Station address bytes, byte 0 in bits 7:0 |
| host_rd | input | 1 | Host read strobe on the data port |
| host_wr | input | 1 | Host write strobe on the data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdy | output | 1 | Low to stretch the current host cycle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data is valid with it |
| mem_rdata | input | 16 | Memory read data |

## Verification
The bench targets the handshake edges. A read issued right after start must be stretched, and a design that let it through would hand back a stale or zero word. Back-to-back writes must stall the second one, and a design that skipped the stall would overwrite the uncommitted word, so memory would receive the wrong data. The bench also counts memory accesses while the host is idle. An extra count would expose a design that runs ahead of a one-word prefetch, and one that commits writes with no new word behind them. On the address map it sweeps the whole register area in both modes. A wrong alias or a wrong step would show up as misplaced station bytes or the wrong signature. It also drives an odd count in 16-bit mode, where a count that is decremented without saturating would never raise done.

// File: rtl/hdp_pkg.sv
`timescale 1ns/1ps
package hdp_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 16;
  localparam int COUNT_W   = 16;
  localparam int BYTE_W    = 8;
  localparam int STA_BYTES = 6;

  localparam logic [ADDR_W-1:0] REG16_LIMIT = 16'h0020;
  localparam logic [ADDR_W-1:0] RAM8_BASE   = 16'h4000;
  localparam logic [ADDR_W-1:0] RSV8_BASE   = 16'h6000;
  localparam logic [BYTE_W-1:0] SIG_WIDE    = 8'h57;
  localparam logic [BYTE_W-1:0] SIG_NARROW  = 8'h42;

  typedef enum logic [1:0] {
    RGN_RAM = 2'd0,
    RGN_REG = 2'd1,
    RGN_RSV = 2'd2
  } region_e;

  // Local map: which target an address reaches in the given mode.
  function automatic region_e classify(input logic [ADDR_W-1:0] a, input logic wide);
    if (wide) return (a < REG16_LIMIT) ? RGN_REG : RGN_RAM;
    if (a < RAM8_BASE) return RGN_REG;
    if (a < RSV8_BASE) return RGN_RAM;
    return RGN_RSV;
  endfunction

  // Register-area byte; narrow mode folds odd offsets onto even ones.
  function automatic logic [BYTE_W-1:0] reg_byte(input logic [4:0] off, input logic wide,
                                                 input logic [BYTE_W*STA_BYTES-1:0] sta);
    int slot;
    if (off[4:1] == 4'hF) return wide ? SIG_WIDE : SIG_NARROW;
    slot = wide ? int'(off) : int'(off[4:1]);
    if (slot < STA_BYTES) return sta[slot*BYTE_W +: BYTE_W];
    return '0;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_step(input logic wide);
    return wide ? ADDR_W'(2) : ADDR_W'(1);
  endfunction

  function automatic logic [COUNT_W-1:0] count_after(input logic [COUNT_W-1:0] cnt,
                                                     input logic wide);
    logic [COUNT_W-1:0] dec;
    dec = wide ? COUNT_W'(2) : COUNT_W'(1);
    return (cnt > dec) ? cnt - dec : '0;
  endfunction

  function automatic logic count_is_last(input logic [COUNT_W-1:0] cnt, input logic wide);
    return wide ? (cnt <= COUNT_W'(2)) : (cnt <= COUNT_W'(1));
  endfunction

  function automatic logic [DATA_W-1:0] lane_fit(input logic [DATA_W-1:0] d, input logic wide);
    return wide ? d : {{(DATA_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
  endfunction
endpackage

// File: rtl/hdp_decode.sv
`timescale 1ns/1ps
module hdp_decode #(
  parameter int AW    = hdp_pkg::ADDR_W,
  parameter int DW    = hdp_pkg::DATA_W,
  parameter int NSTA  = hdp_pkg::STA_BYTES
) (
  input  logic [AW-1:0]     addr,
  input  logic              wide,
  input  logic [8*NSTA-1:0] sta,
  output hdp_pkg::region_e  region,
  output logic [DW-1:0]     local_word
);
  localparam int PAD_W = DW - hdp_pkg::BYTE_W;

  always_comb begin
    region = hdp_pkg::classify(addr, wide);
    if (region == hdp_pkg::RGN_REG)
      local_word = {{PAD_W{1'b0}}, hdp_pkg::reg_byte(addr[4:0], wide, sta)};
    else
      local_word = '0;
  end
endmodule

// File: rtl/hdp_xfer_ctr.sv
`timescale 1ns/1ps
module hdp_xfer_ctr #(
  parameter int AW = hdp_pkg::ADDR_W,
  parameter int CW = hdp_pkg::COUNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          wide,
  input  logic          advance,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      cur_cnt  <= load_cnt;
    end else if (advance) begin
      cur_addr <= cur_addr + hdp_pkg::addr_step(wide);
      cur_cnt  <= hdp_pkg::count_after(cur_cnt, wide);
    end
  end

  assign last = hdp_pkg::count_is_last(cur_cnt, wide);
endmodule

// File: rtl/hdp_hold.sv
`timescale 1ns/1ps
module hdp_hold #(
  parameter int DW = hdp_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  input  logic          drain,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (fill) begin
      valid <= 1'b1;
      data  <= fill_data;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/host_data_port.sv
`timescale 1ns/1ps
module host_data_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode16,
  input  logic        xfer_start,
  input  logic        xfer_write,
  input  logic [15:0] xfer_addr,
  input  logic [15:0] xfer_count,
  output logic        xfer_done,
  input  logic [47:0] station_addr,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_rdy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata
);
  localparam int AW = hdp_pkg::ADDR_W;
  localparam int DW = hdp_pkg::DATA_W;
  localparam int CW = hdp_pkg::COUNT_W;

  logic active_q, dir_wr_q, wide_q, done_q;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt;
  logic          last;
  logic          hold_valid;
  logic [DW-1:0] hold_data;
  hdp_pkg::region_e region;
  logic [DW-1:0] local_word;

  // Named events, also observed by the checker.
  logic rd_dir, wr_dir, on_ram;
  logic rd_fill_mem, rd_fill_loc, rd_filled;
  logic host_take, wr_take, wr_commit_mem, wr_drop, wr_retire, advance;
  logic hold_fill;
  logic [DW-1:0] hold_fill_data;

  hdp_decode #(.AW(AW), .DW(DW), .NSTA(hdp_pkg::STA_BYTES)) decode_i (
    .addr(cur_addr), .wide(wide_q), .sta(station_addr),
    .region(region), .local_word(local_word)
  );

  hdp_xfer_ctr #(.AW(AW), .CW(CW)) ctr_i (
    .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_addr(xfer_addr),
    .load_cnt(xfer_count), .wide(wide_q), .advance(advance),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .last(last)
  );

  hdp_hold #(.DW(DW)) hold_i (
    .clk(clk), .rst_n(rst_n), .clear(xfer_start), .fill(hold_fill),
    .fill_data(hold_fill_data), .drain(host_take | wr_retire),
    .valid(hold_valid), .data(hold_data)
  );

  always_comb begin
    rd_dir        = active_q & ~dir_wr_q;
    wr_dir        = active_q & dir_wr_q;
    on_ram        = (region == hdp_pkg::RGN_RAM);
    rd_fill_mem   = rd_dir & ~hold_valid & on_ram;
    rd_fill_loc   = rd_dir & ~hold_valid & ~on_ram;
    rd_filled     = (rd_fill_mem & mem_ack) | rd_fill_loc;
    host_take     = host_rd & rd_dir & hold_valid;
    wr_take       = host_wr & wr_dir & ~hold_valid;
    wr_commit_mem = wr_dir & hold_valid & on_ram;
    wr_drop       = wr_dir & hold_valid & ~on_ram;
    wr_retire     = (wr_commit_mem & mem_ack) | wr_drop;
    advance       = host_take | wr_retire;
    hold_fill     = rd_filled | wr_take;
    if (wr_take)          hold_fill_data = hdp_pkg::lane_fit(host_wdata, wide_q);
    else if (rd_fill_loc) hold_fill_data = local_word;
    else                  hold_fill_data = hdp_pkg::lane_fit(mem_rdata, wide_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_wr_q <= 1'b0;
      wide_q   <= 1'b1;
      done_q   <= 1'b0;
    end else if (xfer_start) begin
      active_q <= |xfer_count;
      dir_wr_q <= xfer_write;
      wide_q   <= mode16;
      done_q   <= ~|xfer_count;
    end else if (advance && last) begin
      active_q <= 1'b0;
      done_q   <= 1'b1;
    end
  end

  assign mem_req    = rd_fill_mem | wr_commit_mem;
  assign mem_we     = wr_dir;
  assign mem_addr   = cur_addr;
  assign mem_wdata  = hold_data;
  assign host_rdy   = ~((host_rd & rd_dir & ~hold_valid) | (host_wr & wr_dir & hold_valid));
  assign host_rdata = (rd_dir & hold_valid) ? hold_data : '0;
  assign xfer_done  = done_q;
endmodule

// File: rtl/hdp_checker.sv
`timescale 1ns/1ps
module hdp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_start,
  input logic        xfer_done,
  input logic        host_wr,
  input logic        host_rdy,
  input logic        wr_take,
  input logic        wide_q,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [15:0] mem_addr
);
  // R2: a pending request keeps its address and kind until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !xfer_start) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3: after a read lands, no further read request the next cycle
  p_one_deep_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we && !xfer_start) |=> !mem_req);

  // R4: a second write right after acceptance is stalled
  p_write_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && !xfer_start) |=> (!host_wr || !host_rdy));

  // R5: a committed write is not followed by another without a new word
  p_write_needs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we && !xfer_start) |=> !mem_req);

  // R6: a finished transfer makes no memory request
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !mem_req);

  // R7: in wide mode the register area never reaches memory
  p_reg16_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && wide_q) |-> (mem_addr >= 16'h0020));

  // R9: in narrow mode memory is reached only inside the buffer window
  p_ram8_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !wide_q) |-> (mem_addr >= 16'h4000 && mem_addr < 16'h6000));
endmodule

bind host_data_port hdp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_done(xfer_done),
  .host_wr(host_wr), .host_rdy(host_rdy), .wr_take(wr_take), .wide_q(wide_q),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/host_data_port_tb_top.sv
`timescale 1ns/1ps
module host_data_port_tb_top;
  localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode16 = 1'b1, xfer_start = 1'b0, xfer_write = 1'b0;
  logic [15:0] xfer_addr = '0, xfer_count = '0;
  logic xfer_done;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic host_rdy;
  logic mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #2 clk = ~clk;

  host_data_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .xfer_start(xfer_start),
    .xfer_write(xfer_write), .xfer_addr(xfer_addr), .xfer_count(xfer_count),
    .xfer_done(xfer_done), .station_addr(STA), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b1;
  int mem_lat = 3;
  int accesses = 0;
  logic [15:0] mem_arr [256];

  logic [15:0] exp_rd_q[$];
  string       exp_rd_tag[$];
  logic [31:0] exp_wr_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sta_byte(input int j);
    return STA[8*j +: 8];
  endfunction

  function automatic logic [15:0] exp_wide_reg(input logic [4:0] off);
    if (off == 5'h1E || off == 5'h1F) return 16'h0057;
    if (off < 5'd6) return {8'h00, sta_byte(int'(off))};
    return 16'h0000;
  endfunction

  function automatic logic [15:0] exp_narrow_reg(input logic [15:0] a);
    logic [4:0] even;
    even = a[4:0] & 5'h1E;
    if (even == 5'h1E) return 16'h0042;
    if (even < 5'd12) return {8'h00, sta_byte(int'(even) / 2)};
    return 16'h0000;
  endfunction

  // Memory model with scoreboard check of every write it receives.
  initial begin
    int lat_cnt = 0;
    for (int i = 0; i < 256; i++) mem_arr[i] = {~8'(i), 8'(i)};
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (lat_cnt >= mem_lat) begin
          mem_ack = 1'b1;
          lat_cnt = 0;
          accesses++;
          if (mem_we) begin
            logic [31:0] got, want;
            got = {mem_addr, mem_wdata};
            if (exp_wr_q.size() == 0) chk(1'b0, "R4|R5 unexpected write", got, 32'h0);
            else begin
              want = exp_wr_q.pop_front();
              chk(got == want, "R4|R9 memory write", got, want);
            end
            mem_arr[mem_addr[7:0]] = mem_wdata;
          end else begin
            mem_rdata = mem_arr[mem_addr[7:0]];
          end
        end else begin
          mem_ack = 1'b0;
          lat_cnt++;
        end
      end else begin
        mem_ack = 1'b0;
        lat_cnt = 0;
      end
    end
  end

  // Read monitor: compares each accepted host read with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_en && host_rd && host_rdy) begin
        if (exp_rd_q.size() == 0) chk(1'b0, "R2 unexpected read", {16'h0, host_rdata}, 32'h0);
        else begin
          logic [15:0] want;
          string tag;
          want = exp_rd_q.pop_front();
          tag = exp_rd_tag.pop_front();
          chk(host_rdata == want, tag, {16'h0, host_rdata}, {16'h0, want});
        end
      end
    end
  end

  task automatic start_xfer(input logic [15:0] a, input logic [15:0] c, input bit wr, input bit wide);
    @(negedge clk);
    xfer_addr = a; xfer_count = c; xfer_write = wr; mode16 = wide; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic host_read(output int waits);
    waits = 0;
    @(negedge clk);
    host_rd = 1'b1;
    #0.5;
    while (!host_rdy && waits < 1000) begin
      waits++;
      @(negedge clk);
      #0.5;
    end
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic host_write(input logic [15:0] d, output int waits);
    waits = 0;
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = d;
    #0.5;
    while (!host_rdy && waits < 1000) begin
      waits++;
      @(negedge clk);
      #0.5;
    end
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!xfer_done && n < 200) begin
      @(negedge clk);
      #0.5;
      n++;
    end
  endtask

  task automatic push_rd(input logic [15:0] d, input string tag);
    exp_rd_q.push_back(d);
    exp_rd_tag.push_back(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w, base;
    repeat (3) @(negedge clk);
    #0.5;
    // R1 reset state
    chk(host_rdy == 1'b1, "R1 rdy after reset", host_rdy, 1);
    chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
    chk(host_rdata == 16'h0, "R1 rdata after reset", host_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk(xfer_done == 1'b0, "R1 done after reset", xfer_done, 0);

    // R2/R3/R6: 16-bit memory read, prefetch then host drains
    base = accesses;
    start_xfer(16'h0100, 16'd6, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk(accesses - base == 1, "R3 single prefetch while host idle", accesses - base, 1);
    for (int k = 0; k < 3; k++) push_rd(mem_arr[8'h00 + 2*k], "R2|R6 wide read data");
    host_read(w);
    chk(w == 0, "R2 prefetched word served without wait", w, 0);
    host_read(w);
    chk(w > 0, "R2 early read stretched", w, 1);
    host_read(w);
    #0.5;
    chk(xfer_done == 1'b1, "R6 done after last word", xfer_done, 1);
    chk(accesses - base == 3, "R3 one fetch per word", accesses - base, 3);

    // R1 idle strobes
    mon_en = 1'b0;
    @(negedge clk); host_rd = 1'b1; host_wr = 1'b1; #0.5;
    chk(host_rdy == 1'b1, "R1 rdy high when idle", host_rdy, 1);
    chk(host_rdata == 16'h0, "R1 rdata zero when idle", host_rdata, 0);
    @(negedge clk); host_rd = 1'b0; host_wr = 1'b0;
    mon_en = 1'b1;

    // R6 odd count in 16-bit mode saturates
    start_xfer(16'h0110, 16'd3, 1'b0, 1'b1);
    push_rd(mem_arr[8'h10], "R6 odd count word 0");
    push_rd(mem_arr[8'h12], "R6 odd count word 1");
    host_read(w);
    host_read(w);
    #0.5;
    chk(xfer_done == 1'b1, "R6 odd count finishes", xfer_done, 1);

    // R6 zero count
    base = accesses;
    start_xfer(16'h0120, 16'd0, 1'b0, 1'b1);
    #0.5;
    chk(xfer_done == 1'b1, "R6 zero count done", xfer_done, 1);
    repeat (6) @(negedge clk);
    chk(accesses == base, "R6 zero count no access", accesses - base, 0);

    // R4/R5: 16-bit write
    base = accesses;
    start_xfer(16'h0200, 16'd4, 1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk(accesses == base, "R5 no write before host word", accesses - base, 0);
    exp_wr_q.push_back({16'h0200, 16'h1111});
    exp_wr_q.push_back({16'h0202, 16'h2222});
    host_write(16'h1111, w);
    chk(w == 0, "R4 empty holding accepts at once", w, 0);
    host_write(16'h2222, w);
    chk(w > 0, "R4 second write stretched", w, 1);
    wait_done();
    chk(xfer_done == 1'b1, "R6 write transfer done", xfer_done, 1);
    chk(accesses - base == 2, "R5 one commit per word", accesses - base, 2);

    // R7: 16-bit register area
    base = accesses;
    start_xfer(16'h0000, 16'd32, 1'b0, 1'b1);
    for (int k = 0; k < 16; k++) begin
      push_rd(exp_wide_reg(5'(2*k)), "R7 wide register byte");
      host_read(w);
    end
    #0.5;
    chk(xfer_done == 1'b1, "R7 register sweep done", xfer_done, 1);
    chk(accesses == base, "R7 no memory access", accesses - base, 0);
    start_xfer(16'h001F, 16'd2, 1'b0, 1'b1);
    push_rd(16'h0057, "R7 odd top offset signature");
    host_read(w);

    // R8: 8-bit aliased register area
    start_xfer(16'h2A00, 16'd32, 1'b0, 1'b0);
    for (int k = 0; k < 32; k++) begin
      push_rd(exp_narrow_reg(16'h2A00 + 16'(k)), "R8 narrow mirrored byte");
      host_read(w);
    end
    #0.5;
    chk(accesses == base, "R8 no memory access", accesses - base, 0);

    // R9: 8-bit memory read (low lane only) and reserved read
    start_xfer(16'h4010, 16'd3, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      push_rd({8'h00, mem_arr[8'h10 + k][7:0]}, "R9 narrow memory byte");
      host_read(w);
    end
    chk(accesses - base == 3, "R9 narrow memory fetches", accesses - base, 3);
    base = accesses;
    start_xfer(16'h6000, 16'd2, 1'b0, 1'b0);
    push_rd(16'h0000, "R9 reserved read zero");
    push_rd(16'h0000, "R9 reserved read zero");
    host_read(w);
    host_read(w);
    chk(accesses == base, "R9 reserved no access", accesses - base, 0);

    // R9: 8-bit write lane and step
    exp_wr_q.push_back({16'h4020, 16'h00EF});
    exp_wr_q.push_back({16'h4021, 16'h00FE});
    start_xfer(16'h4020, 16'd2, 1'b1, 1'b0);
    host_write(16'hBEEF, w);
    host_write(16'hCAFE, w);
    wait_done();
    base = accesses;

    // R9: reserved write dropped; R10: register-area write dropped
    start_xfer(16'h7000, 16'd1, 1'b1, 1'b0);
    host_write(16'h5A5A, w);
    wait_done();
    chk(xfer_done == 1'b1, "R9 reserved write completes", xfer_done, 1);
    start_xfer(16'h0004, 16'd2, 1'b1, 1'b1);
    host_write(16'hA5A5, w);
    wait_done();
    chk(xfer_done == 1'b1, "R10 register write completes", xfer_done, 1);
    repeat (4) @(negedge clk);
    chk(accesses == base, "R10 dropped writes no access", accesses - base, 0);
    start_xfer(16'h0004, 16'd2, 1'b0, 1'b1);
    push_rd({8'h00, sta_byte(4)}, "R10 register area unchanged");
    host_read(w);

    repeat (4) @(negedge clk);
    chk(exp_rd_q.size() == 0, "R2 all expected reads seen", exp_rd_q.size(), 0);
    chk(exp_wr_q.size() == 0, "R4 all expected writes seen", exp_wr_q.size(), 0);
    finish_run();
  end
endmodule